// File: doc/BRIEF.md
# Parallel DAC Write-Cycle Sequencer

This block converts samples from a synchronous host into timed write cycles on the parallel load port of a latch-input multiplying DAC. The host hands over one 12-bit sample at a time on a valid/ready handshake, together with a flag that says whether the sample is unsigned or two's complement. The sequencer then drives the converter's active-low chip select, active-low write strobe and data bus.

The converter's input latches follow the bus whenever both strobes are low. To keep settling or stale bus values away from the analog output, every cycle runs in a fixed order. The bus is driven first with the strobes high. Both strobes then go low together for a minimum pulse. After they rise, the bus is held unchanged before the next sample may be accepted. Each interval is a whole number of clock cycles, worked out at elaboration by rounding a nanosecond minimum up against the clock period, and each is at least one cycle. Two's complement samples reach the bus as offset binary: the top bit is inverted and the rest pass through unchanged.

Top module: `dac_load_seq`

## Requirements
- R1: While reset is asserted and after it is released, `dac_cs_n` and `dac_wr_n` are 1, `dac_bus` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 only while the sequencer is idle. A sample is taken when `in_valid` and `in_ready` are both 1 at a clock edge. `in_ready` then stays 0 until the hold interval has ended.
- R3: `dac_bus` takes the converted sample in the cycle after acceptance. Both strobes stay high for SETUP_CYC cycles from that cycle.
- R4: `dac_cs_n` and `dac_wr_n` are both 0 for exactly PULSE_CYC consecutive cycles per accepted sample.
- R5: After the strobes rise, they stay high and `dac_bus` is unchanged for HOLD_CYC cycles. `in_ready` returns to 1 in the cycle after that.
- R6: `dac_bus` does not change in any cycle in which both strobes are low, and in no cycle just before one.
- R7: With `in_signed` = 0, the code written (and latched by the DAC) equals `in_data` bit for bit.
- R8: With `in_signed` = 1, the code written equals `in_data` with bit 11 inverted. For example, 0x7FF gives 0xFFF, 0x800 gives 0x000 and 0x000 gives 0x800.
- R9: Changes of `in_data`, `in_signed` or `in_valid` while `in_ready` is 0 have no effect on `dac_bus` or on the strobes.
- R10: `dac_bus` changes only in the cycle after an acceptance. Otherwise, including while idle, it keeps the last code written.
- R11: `dac_cs_n` and `dac_wr_n` are equal in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Host offers a sample |
| in_ready | output | 1 | Sequencer is idle and will take a sample |
| in_data | input | 12 | Sample, bit 11 most significant |
| in_signed | input | 1 | 1 means two's complement, 0 means unsigned |
| dac_cs_n | output | 1 | Chip select to the DAC, active low |
| dac_wr_n | output | 1 | Write strobe to the DAC, active low |
| dac_bus | output | 12 | Data bus to the DAC latches |

## Verification
The bench targets the edges of each interval: a design off by one in the setup, pulse or hold count would drop a strobe early, stretch it, or raise ready one cycle too soon, and the per-cycle model would catch the mismatch. A latch model flags any bus movement under low strobes, which is what a design that loaded the bus on the same edge as the strobe fall would produce. The format cases place the conversion at the sign boundaries (0x7FF, 0x800, 0x000, 0xFFF), where inverting the wrong bit or negating the value gives a visibly wrong latched code. Junk data and a held valid during a busy cycle, plus back-to-back samples, expose a design that accepts outside idle or rearms ready early.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_DRIVE  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } seq_phase_t;

   // Round a nanosecond minimum up to whole clock cycles, never below one.
   function automatic int unsigned cycles_for(input int unsigned t_ns,
                                              input int unsigned period_ps);
      int unsigned c;
      c = (t_ns * 1000 + period_ps - 1) / period_ps;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/dac_fmt_conv.sv
module dac_fmt_conv #(
   parameter int unsigned DATA_W = 12
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              is_signed,
   output logic [DATA_W-1:0] code
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == DATA_W - 1) begin : g_top
         // offset binary: flip only the sign position
         assign code[b] = raw[b] ^ is_signed;
      end else begin : g_pass
         assign code[b] = raw[b];
      end
   end

endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
   import dac_seq_pkg::*;
#(
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned PULSE_CYC = 1,
   parameter int unsigned HOLD_CYC  = 1,
   parameter int unsigned CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             expired,
   output logic             accept,
   output logic             idle,
   output logic             strobe_n,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

   seq_phase_t phase_q, phase_d;
   logic       strobe_n_q;

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      unique case (phase_q)
         PH_IDLE: if (in_valid) begin
            phase_d  = PH_DRIVE;
            load     = 1'b1;
            load_val = SETUP_LD;
         end
         PH_DRIVE: if (expired) begin
            phase_d  = PH_STROBE;
            load     = 1'b1;
            load_val = PULSE_LD;
         end
         PH_STROBE: if (expired) begin
            phase_d  = PH_HOLD;
            load     = 1'b1;
            load_val = HOLD_LD;
         end
         PH_HOLD: if (expired) begin
            phase_d  = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         strobe_n_q <= 1'b1;
      end else begin
         phase_q    <= phase_d;
         strobe_n_q <= (phase_d != PH_STROBE);
      end
   end

   assign idle     = (phase_q == PH_IDLE);
   assign accept   = idle && in_valid;
   assign strobe_n = strobe_n_q;

endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq
   import dac_seq_pkg::*;
#(
   parameter int unsigned DATA_W   = 12,
   parameter int unsigned CLK_PS   = 5000,
   parameter int unsigned SETUP_NS = 10,
   parameter int unsigned PULSE_NS = 400,
   parameter int unsigned CS_SU_NS = 380,
   parameter int unsigned DSU_NS   = 210,
   parameter int unsigned HOLD_NS  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_signed,
   output logic              dac_cs_n,
   output logic              dac_wr_n,
   output logic [DATA_W-1:0] dac_bus
);

   // Both strobes fall together, so the low pulse also covers the chip
   // select and data setup minimums measured to the write rise.
   localparam int unsigned SETUP_CYC = cycles_for(SETUP_NS, CLK_PS);
   localparam int unsigned PULSE_CYC = max3(cycles_for(PULSE_NS, CLK_PS),
                                            cycles_for(CS_SU_NS, CLK_PS),
                                            cycles_for(DSU_NS, CLK_PS));
   localparam int unsigned HOLD_CYC  = cycles_for(HOLD_NS, CLK_PS);
   localparam int unsigned MAX_CYC   = max3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
   localparam int unsigned CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   if (DATA_W < 2) begin : g_bad_width
      $error("dac_load_seq: DATA_W must be at least 2");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("dac_load_seq: CLK_PS must be nonzero");
   end

   logic              accept;
   logic              idle;
   logic              strobe_n;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic              t_expired;
   logic [DATA_W-1:0] code;
   logic [DATA_W-1:0] bus_q;

   dac_fmt_conv #(.DATA_W(DATA_W)) conv_i (
      .raw       (in_data),
      .is_signed (in_signed),
      .code      (code)
   );

   dac_phase_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   dac_seq_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .CNT_W     (CNT_W)
   ) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .expired  (t_expired),
      .accept   (accept),
      .idle     (idle),
      .strobe_n (strobe_n),
      .load     (t_load),
      .load_val (t_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_q <= '0;
      else if (accept)
         bus_q <= code;
   end

   assign in_ready = idle;
   assign dac_cs_n = strobe_n;
   assign dac_wr_n = strobe_n;
   assign dac_bus  = bus_q;

endmodule

// File: rtl/dac_load_seq_chk.sv
module dac_load_seq_chk #(
   parameter int unsigned DATA_W    = 12,
   parameter int unsigned PULSE_CYC = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              dac_cs_n,
   input logic              dac_wr_n,
   input logic [DATA_W-1:0] dac_bus
);

   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_cnt <= 0;
      else if (!dac_cs_n && !dac_wr_n)
         low_cnt <= low_cnt + 1;
      else
         low_cnt <= 0;
   end

   // R11
   strobes_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_cs_n == dac_wr_n);

   // R6
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_wr_n && !$past(dac_wr_n)) |-> $stable(dac_bus));

   // R2
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R3
   setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_wr_n) |-> !$past(in_ready));

   // R5
   hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> (dac_wr_n && $past(dac_wr_n)));

   // R10
   bus_only_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid && in_ready) |-> $stable(dac_bus));

   // R4
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_wr_n) |-> (low_cnt == PULSE_CYC));

endmodule

bind dac_load_seq dac_load_seq_chk #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .dac_cs_n (dac_cs_n),
   .dac_wr_n (dac_wr_n),
   .dac_bus  (dac_bus)
);

// File: tb/dac_load_seq_tb_top.sv
`timescale 1ns/1ps
module dac_load_seq_tb_top;

   // 5 ns clock; 10 ns -> 2 cycles, 20 ns -> 4 cycles, 5 ns -> 1 cycle
   localparam int SETUP_EXP = 2;
   localparam int PULSE_EXP = 4;
   localparam int HOLD_EXP  = 1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [11:0] in_data;
   logic        in_signed;
   logic        dac_cs_n;
   logic        dac_wr_n;
   logic [11:0] dac_bus;

   always #2.5 clk = ~clk;

   dac_load_seq #(
      .DATA_W(12), .CLK_PS(5000), .SETUP_NS(10), .PULSE_NS(20),
      .CS_SU_NS(15), .DSU_NS(12), .HOLD_NS(5)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_signed(in_signed), .dac_cs_n(dac_cs_n),
      .dac_wr_n(dac_wr_n), .dac_bus(dac_bus)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 drive, 2 strobe, 3 hold
   int          ph   = 0;
   int          left = 0;
   logic [11:0] m_bus = '0;
   logic [11:0] exp_q[$];
   bit          sgn_q[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0; left = 0; m_bus = '0;
      end else begin
         case (ph)
            0: if (in_valid) begin
                  m_bus = in_signed ? {~in_data[11], in_data[10:0]} : in_data;
                  exp_q.push_back(m_bus);
                  sgn_q.push_back(in_signed);
                  ph = 1; left = SETUP_EXP;
               end
            1: if (left == 1) begin ph = 2; left = PULSE_EXP; end else left--;
            2: if (left == 1) begin ph = 3; left = HOLD_EXP; end else left--;
            default: if (left == 1) ph = 0; else left--;
         endcase
      end
   end

   // per-cycle comparison and DAC latch model
   logic [11:0] latch = '0;
   bit          was_low = 0;
   int          low_n = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         string tag;
         case (ph)
            0: tag = "R2 R10 idle";
            1: tag = "R3 drive";
            2: tag = "R4 strobe";
            default: tag = "R5 hold";
         endcase
         chk(in_ready == (ph == 0), {tag, " ready"}, in_ready, ph == 0);
         chk(dac_wr_n == (ph != 2), {tag, " wr_n"}, dac_wr_n, ph != 2);
         chk(dac_bus == m_bus, {tag, " R9 bus"}, dac_bus, m_bus);
         chk(dac_cs_n == dac_wr_n, "R11 cs_n equals wr_n", dac_cs_n, dac_wr_n);
         if (!dac_cs_n && !dac_wr_n) begin
            if (was_low)
               chk(dac_bus == latch, "R6 bus moved under low strobes", dac_bus, latch);
            latch = dac_bus; was_low = 1; low_n++;
         end else if (was_low) begin
            logic [11:0] e;
            bit s;
            was_low = 0;
            chk(low_n == PULSE_EXP, "R4 pulse length", low_n, PULSE_EXP);
            low_n = 0;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 12'hxxx;
            s = (sgn_q.size() > 0) ? sgn_q.pop_front() : 1'b0;
            if (s) chk(latch === e, "R8 latched offset code", latch, e);
            else   chk(latch === e, "R7 latched code", latch, e);
         end
      end
   end

   task automatic send(input logic [11:0] d, input bit s, input bit junk);
      in_data = d; in_signed = s; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (junk) begin
         in_data = ~d; in_signed = ~s;   // R9 stimulus while busy
         while (!in_ready) @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_signed = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(dac_cs_n == 1'b1, "R1 cs_n in reset", dac_cs_n, 1);
      chk(dac_wr_n == 1'b1, "R1 wr_n in reset", dac_wr_n, 1);
      chk(dac_bus == 12'h000, "R1 bus in reset", dac_bus, 0);
      chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R7 unsigned patterns
      send(12'h123, 1'b0, 1'b0);
      send(12'hFFF, 1'b0, 1'b0);
      send(12'h000, 1'b0, 1'b0);
      send(12'h800, 1'b0, 1'b0);
      // R8 signed boundaries
      send(12'h7FF, 1'b1, 1'b0);
      send(12'h800, 1'b1, 1'b0);
      send(12'h000, 1'b1, 1'b0);
      send(12'hFFF, 1'b1, 1'b0);
      // R9 junk and held valid while busy
      send(12'h5A5, 1'b0, 1'b1);
      send(12'h3C3, 1'b1, 1'b1);
      // R10 idle gap: bus keeps last code (0x3C3 signed -> 0xBC3)
      repeat (6) @(negedge clk);
      chk(dac_bus == 12'hBC3, "R10 bus kept while idle", dac_bus, 12'hBC3);
      // back-to-back samples
      for (int i = 0; i < 6; i++) send(12'(i * 12'h2A7), i[0], 1'b0);
      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R4 every sample strobed", exp_q.size(), 0);
      finish_run();
   end

endmodule